// File: doc/BRIEF.md
# Constant-Weight N-Choose-M Codec

This block converts binary words to and from constant-weight codewords for a parallel bus of `N` wires. Every symbol placed on the bus has exactly `M` wires at one and `N-M` at zero. The number of legal symbols is the binomial coefficient C(N,M). The binary side is `floor(log2(C(N,M)))` bits wide, so the top legal codewords are never produced by the encoder.

The transmit half takes a binary word and ranks it into a codeword using the combinatorial number system. A binomial table is fixed at elaboration, and the encoder walks the wires from the most significant down, subtracting binomial coefficients. The receive half takes a codeword in which each wire has already been judged as a one or a zero. It counts the ones, sums binomial coefficients at the set positions to recover the rank, and flags symbols that cannot have come from a correct encoder. Both halves accept a valid strobe and present a registered result one clock later.

Top module: `cw_codec`

## Requirements
- R1: Every codeword the encoder presents with `enc_valid_o` high has exactly M bits set.
- R2: For input value v, the encoder outputs the (v+1)-th smallest N-bit unsigned integer whose population count is M. Bit i of `enc_code_o` is wire i, and bit N-1 is the most significant.
- R3: A codeword produced for value v decodes back to v, with both error flags low.
- R4: A received symbol whose population count differs from M raises `dec_weight_err_o`. In that case `dec_unused_err_o` is low and `dec_data_o` is zero.
- R5: A received symbol of weight M whose rank (as defined in R2) is at least 2^DW raises `dec_unused_err_o`. In that case `dec_weight_err_o` is low and `dec_data_o` is zero.
- R6: The data width DW equals floor(log2(C(N,M))). This gives 6 for N=8, M=4; 4 for N=6, M=3; and 2 for N=4, M=2. The default parameters are N=8 and M=N/2.
- R7: Each half has one cycle of latency. The output valid in a cycle equals the input valid sampled at the previous rising edge.
- R8: When the input valid is low at an edge, the output valid is low after that edge and the other outputs of that half keep their previous values.
- R9: A low level on `rst_n` clears every output to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input word is valid |
| enc_data_i | input | DW | Binary word to encode |
| enc_valid_o | output | 1 | Encoder output codeword is valid |
| enc_code_o | output | N | Constant-weight codeword, one bit per wire |
| dec_valid_i | input | 1 | Received codeword is valid |
| dec_code_i | input | N | Received codeword, one bit per wire |
| dec_valid_o | output | 1 | Decoder outputs are valid |
| dec_data_o | output | DW | Recovered binary word, zero on error |
| dec_weight_err_o | output | 1 | Received symbol had the wrong number of ones |
| dec_unused_err_o | output | 1 | Received symbol was legal in weight but outside the data range |

## Verification
The assertions check, on every cycle, the properties that hold locally. These are the constant weight of every encoder output, the one-cycle valid timing, the hold of outputs when no input is valid, the weight flag against the previous input's population count, the zero data word on any error, and the cleared outputs under reset. Only the bench scenarios can show that the mapping is correct. The bench sweeps every input of the default configuration and of the N=6 and N=4 configurations, comparing against an ordering of weight-M integers that it computes itself, and it checks the loopback of the encoder into the decoder. The asynchronous clear in the middle of a run is also shown only by the bench.

// File: rtl/cw_codec_pkg.sv
package cw_codec_pkg;

    // Binomial coefficient, exact at every step of the product.
    function automatic longint unsigned binom(input int n, input int k);
        longint unsigned r;
        if (k < 0 || k > n) return 0;
        r = 1;
        for (int i = 1; i <= k; i++) begin
            r = r * longint'(n - k + i) / longint'(i);
        end
        return r;
    endfunction

    // floor(log2(x)) for x >= 1
    function automatic int flog2(input longint unsigned x);
        longint unsigned v;
        int r;
        v = x;
        r = 0;
        while (v > 1) begin
            v = v >> 1;
            r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/cw_binom_table.sv
module cw_binom_table
    import cw_codec_pkg::*;
#(
    parameter int N  = 8,
    parameter int M  = 4,
    parameter int CW = N + 1
) (
    output logic [N*(M+1)*CW-1:0] tab_o
);

    // Entry (p,k) holds C(p,k) for wire position p and remaining weight k.
    for (genvar p = 0; p < N; p++) begin : g_pos
        for (genvar k = 0; k <= M; k++) begin : g_wt
            assign tab_o[(p*(M+1)+k)*CW +: CW] = CW'(binom(p, k));
        end
    end

endmodule

// File: rtl/cw_encoder.sv
module cw_encoder #(
    parameter int N  = 8,
    parameter int M  = 4,
    parameter int DW = 6,
    parameter int CW = N + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic [DW-1:0]           data_i,
    input  logic [N*(M+1)*CW-1:0]   tab_i,
    output logic                    valid_o,
    output logic [N-1:0]            code_o
);

    typedef struct packed {
        logic         valid;
        logic [N-1:0] code;
    } enc_state_t;

    enc_state_t st_d, st_q;
    logic [N-1:0] code_c;

    // Unranking: walk from the top wire, take a one when the remaining
    // rank reaches the count of patterns that keep this wire at zero.
    always_comb begin : enc_unrank
        logic [CW-1:0] rem;
        logic [CW-1:0] coef;
        int            left;
        rem    = CW'(data_i);
        left   = M;
        code_c = '0;
        coef   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (left > 0) begin
                coef = tab_i[(p*(M+1)+left)*CW +: CW];
                if (rem >= coef) begin
                    code_c[p] = 1'b1;
                    rem       = rem - coef;
                    left      = left - 1;
                end
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.code = code_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign code_o  = st_q.code;

endmodule

// File: rtl/cw_decoder.sv
module cw_decoder #(
    parameter int N  = 8,
    parameter int M  = 4,
    parameter int DW = 6,
    parameter int CW = N + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic [N-1:0]            code_i,
    input  logic [N*(M+1)*CW-1:0]   tab_i,
    output logic                    valid_o,
    output logic [DW-1:0]           data_o,
    output logic                    weight_err_o,
    output logic                    unused_err_o
);

    localparam logic [CW-1:0] LIMIT = CW'(1) << DW;

    typedef struct packed {
        logic          valid;
        logic          werr;
        logic          uerr;
        logic [DW-1:0] data;
    } dec_state_t;

    dec_state_t    st_d, st_q;
    logic [CW-1:0] rank_c;
    int            ones_c;

    // Ranking: the j-th one from the bottom at wire p adds C(p,j).
    always_comb begin : dec_rank
        rank_c = '0;
        ones_c = 0;
        for (int p = 0; p < N; p++) begin
            if (code_i[p]) begin
                ones_c = ones_c + 1;
                if (ones_c <= M) begin
                    rank_c = rank_c + tab_i[(p*(M+1)+ones_c)*CW +: CW];
                end
            end
        end
    end

    always_comb begin
        logic werr_c;
        logic uerr_c;
        werr_c     = (ones_c != M);
        uerr_c     = !werr_c && (rank_c >= LIMIT);
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.werr = werr_c;
            st_d.uerr = uerr_c;
            st_d.data = (werr_c || uerr_c) ? '0 : rank_c[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o      = st_q.valid;
    assign data_o       = st_q.data;
    assign weight_err_o = st_q.werr;
    assign unused_err_o = st_q.uerr;

endmodule

// File: rtl/cw_codec.sv
module cw_codec
    import cw_codec_pkg::*;
#(
    parameter  int N  = 8,
    parameter  int M  = N / 2,
    localparam int DW = flog2(binom(N, M))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_valid_i,
    input  logic [DW-1:0] enc_data_i,
    output logic          enc_valid_o,
    output logic [N-1:0]  enc_code_o,
    input  logic          dec_valid_i,
    input  logic [N-1:0]  dec_code_i,
    output logic          dec_valid_o,
    output logic [DW-1:0] dec_data_o,
    output logic          dec_weight_err_o,
    output logic          dec_unused_err_o
);

    // Any sum of table entries stays below 2^N, so N+1 bits suffice.
    localparam int CW = N + 1;

    logic [N*(M+1)*CW-1:0] tab;

    cw_binom_table #(.N(N), .M(M), .CW(CW)) tab_i (
        .tab_o (tab)
    );

    cw_encoder #(.N(N), .M(M), .DW(DW), .CW(CW)) enc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .tab_i   (tab),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    cw_decoder #(.N(N), .M(M), .DW(DW), .CW(CW)) dec_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (dec_valid_i),
        .code_i       (dec_code_i),
        .tab_i        (tab),
        .valid_o      (dec_valid_o),
        .data_o       (dec_data_o),
        .weight_err_o (dec_weight_err_o),
        .unused_err_o (dec_unused_err_o)
    );

endmodule

// File: rtl/cw_codec_checker.sv
module cw_codec_checker
    import cw_codec_pkg::*;
#(
    parameter  int N  = 8,
    parameter  int M  = N / 2,
    localparam int DW = flog2(binom(N, M))
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_valid_i,
    input logic          enc_valid_o,
    input logic [N-1:0]  enc_code_o,
    input logic          dec_valid_i,
    input logic [N-1:0]  dec_code_i,
    input logic          dec_valid_o,
    input logic [DW-1:0] dec_data_o,
    input logic          dec_weight_err_o,
    input logic          dec_unused_err_o
);

    // High once at least one edge has passed since reset release.
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_enc_weight_R1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> ($countones(enc_code_o) == M));

    assert_enc_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (enc_valid_o == $past(enc_valid_i)));

    assert_dec_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (dec_valid_o == $past(dec_valid_i)));

    assert_weight_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && dec_valid_o) |->
            (dec_weight_err_o == ($countones($past(dec_code_i)) != M)));

    assert_err_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && (dec_weight_err_o || dec_unused_err_o)) |->
            (dec_data_o == '0 && !(dec_weight_err_o && dec_unused_err_o)));

    assert_enc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(enc_valid_i)) |-> $stable(enc_code_o));

    assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(dec_valid_i)) |->
            ($stable(dec_data_o) && $stable(dec_weight_err_o) && $stable(dec_unused_err_o)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> (!enc_valid_o && !dec_valid_o && enc_code_o == '0 &&
                    dec_data_o == '0 && !dec_weight_err_o && !dec_unused_err_o));

endmodule

bind cw_codec cw_codec_checker #(.N(N), .M(M)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .enc_valid_i      (enc_valid_i),
    .enc_valid_o      (enc_valid_o),
    .enc_code_o       (enc_code_o),
    .dec_valid_i      (dec_valid_i),
    .dec_code_i       (dec_code_i),
    .dec_valid_o      (dec_valid_o),
    .dec_data_o       (dec_data_o),
    .dec_weight_err_o (dec_weight_err_o),
    .dec_unused_err_o (dec_unused_err_o)
);

// File: tb/cw_codec_tb_top.sv
`timescale 1ns/1ps
module cw_codec_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Default configuration N=8, M=4, DW=6
    logic       a_ev, a_evo, a_dv, a_dvo, a_we, a_ue;
    logic [5:0] a_ed, a_dd;
    logic [7:0] a_ec, a_dc;
    // N=6, M=3, DW=4
    logic       b_ev, b_evo, b_dv, b_dvo, b_we, b_ue;
    logic [3:0] b_ed, b_dd;
    logic [5:0] b_ec, b_dc;
    // N=4, M=2, DW=2
    logic       c_ev, c_evo, c_dv, c_dvo, c_we, c_ue;
    logic [1:0] c_ed, c_dd;
    logic [3:0] c_ec, c_dc;

    cw_codec dut_i (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(a_ev), .enc_data_i(a_ed), .enc_valid_o(a_evo), .enc_code_o(a_ec),
        .dec_valid_i(a_dv), .dec_code_i(a_dc), .dec_valid_o(a_dvo), .dec_data_o(a_dd),
        .dec_weight_err_o(a_we), .dec_unused_err_o(a_ue));

    cw_codec #(.N(6), .M(3)) dut63_i (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(b_ev), .enc_data_i(b_ed), .enc_valid_o(b_evo), .enc_code_o(b_ec),
        .dec_valid_i(b_dv), .dec_code_i(b_dc), .dec_valid_o(b_dvo), .dec_data_o(b_dd),
        .dec_weight_err_o(b_we), .dec_unused_err_o(b_ue));

    cw_codec #(.N(4), .M(2)) dut42_i (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(c_ev), .enc_data_i(c_ed), .enc_valid_o(c_evo), .enc_code_o(c_ec),
        .dec_valid_i(c_dv), .dec_code_i(c_dc), .dec_valid_o(c_dvo), .dec_data_o(c_dd),
        .dec_weight_err_o(c_we), .dec_unused_err_o(c_ue));

    function automatic int pop(input int w);
        int c = 0;
        for (int i = 0; i < 16; i++) c += (w >> i) & 1;
        return c;
    endfunction

    // (v+1)-th smallest n-bit integer with m ones
    function automatic int exp_code(input int n, input int m, input int v);
        int cnt = 0;
        for (int w = 0; w < (1 << n); w++) begin
            if (pop(w) == m) begin
                if (cnt == v) return w;
                cnt++;
            end
        end
        return -1;
    endfunction

    // number of weight-m integers below w
    function automatic int exp_rank(input int m, input int w);
        int cnt = 0;
        for (int x = 0; x < w; x++) if (pop(x) == m) cnt++;
        return cnt;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check one decoder result against the arithmetic expectation (R3 R4 R5)
    task automatic chk_dec(input int n, input int m, input int dw, input int w,
                           input logic vo, input logic we, input logic ue, input int dd);
        int r;
        chk(vo == 1'b1, "R7 dec valid", int'(vo), 1);
        if (pop(w) != m) begin
            chk(we == 1'b1 && ue == 1'b0 && dd == 0, "R4 weight error",
                {29'd0, we, ue, 1'b0} | (dd << 3), 4);
        end else begin
            r = exp_rank(m, w);
            if (r >= (1 << dw)) begin
                chk(we == 1'b0 && ue == 1'b1 && dd == 0, "R5 unused error",
                    {29'd0, we, ue, 1'b0} | (dd << 3), 2);
            end else begin
                chk(we == 1'b0 && ue == 1'b0 && dd == r, "R3 decode rank", dd, r);
            end
        end
    endtask

    task automatic drive_idle();
        a_ev = 0; a_ed = '0; a_dv = 0; a_dc = '0;
        b_ev = 0; b_ed = '0; b_dv = 0; b_dc = '0;
        c_ev = 0; c_ed = '0; c_dv = 0; c_dc = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] keep_code;
        logic [5:0] keep_data;
        drive_idle();
        #1;
        // Reset state (R9)
        chk(a_evo == 0 && a_ec == 0 && a_dvo == 0 && a_dd == 0 && a_we == 0 && a_ue == 0,
            "R9 reset state", int'(a_ec), 0);
        // Data widths (R6)
        chk($bits(dut_i.enc_data_i) == 6, "R6 width 8/4", $bits(dut_i.enc_data_i), 6);
        chk($bits(dut63_i.dec_data_o) == 4, "R6 width 6/3", $bits(dut63_i.dec_data_o), 4);
        chk($bits(dut42_i.dec_data_o) == 2, "R6 width 4/2", $bits(dut42_i.dec_data_o), 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep of all three configurations (R1 R2 R3 R4 R5 R7)
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            a_ev = 1; a_ed = 6'(i % 64); a_dv = 1; a_dc = 8'(i);
            b_ev = 1; b_ed = 4'(i % 16); b_dv = 1; b_dc = 6'(i % 64);
            c_ev = 1; c_ed = 2'(i % 4);  c_dv = 1; c_dc = 4'(i % 16);
            @(posedge clk);
            #1;
            chk(a_evo == 1'b1, "R7 enc valid", int'(a_evo), 1);
            chk(pop(int'(a_ec)) == 4, "R1 weight 8/4", pop(int'(a_ec)), 4);
            chk(int'(a_ec) == exp_code(8, 4, i % 64), "R2 code 8/4", int'(a_ec), exp_code(8, 4, i % 64));
            chk(int'(b_ec) == exp_code(6, 3, i % 16), "R2 code 6/3", int'(b_ec), exp_code(6, 3, i % 16));
            chk(int'(c_ec) == exp_code(4, 2, i % 4), "R2 code 4/2", int'(c_ec), exp_code(4, 2, i % 4));
            chk_dec(8, 4, 6, i, a_dvo, a_we, a_ue, int'(a_dd));
            if (i < 64) chk_dec(6, 3, 4, i, b_dvo, b_we, b_ue, int'(b_dd));
            if (i < 16) chk_dec(4, 2, 2, i, c_dvo, c_we, c_ue, int'(c_dd));
        end

        // Loopback: encoder output fed to the decoder in the next cycle (R3)
        @(negedge clk);
        a_ev = 1; a_ed = 6'd0; a_dv = 0;
        for (int v = 1; v <= 64; v++) begin
            @(negedge clk);
            a_dc = a_ec; a_dv = 1;
            a_ed = 6'(v % 64); a_ev = (v < 64);
            @(posedge clk);
            #1;
            chk(a_dvo && !a_we && !a_ue && int'(a_dd) == v - 1, "R3 loopback", int'(a_dd), v - 1);
        end

        // Hold when no input is valid (R8)
        @(negedge clk);
        a_ev = 1; a_ed = 6'd37; a_dv = 1; a_dc = 8'h0F;
        @(posedge clk);
        #1;
        keep_code = a_ec;
        keep_data = a_dd;
        @(negedge clk);
        a_ev = 0; a_ed = 6'd5; a_dv = 0; a_dc = 8'hFF;
        @(posedge clk);
        #1;
        chk(a_evo == 0 && a_ec == keep_code, "R8 enc hold", int'(a_ec), int'(keep_code));
        chk(a_dvo == 0 && a_dd == keep_data && !a_we && !a_ue, "R8 dec hold", int'(a_dd), int'(keep_data));

        // Asynchronous clear between edges (R9)
        @(negedge clk);
        a_ev = 1; a_ed = 6'd63; a_dv = 1; a_dc = 8'h33;
        @(posedge clk);
        #1.2;
        rst_n = 1'b0;
        #0.3;
        chk(a_evo == 0 && a_ec == 0 && a_dvo == 0 && a_dd == 0, "R9 async clear", int'(a_ec), 0);
        drive_idle();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(a_evo == 0 && a_dvo == 0, "R9 idle after clear", int'(a_evo), 0);

        finish_run();
    end

endmodule